// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Bridge

This block carries data between a peripheral with a 16-bit bus and a byte-addressed memory port. The peripheral makes one request at a time, giving a byte address, a byte length, a direction and a swap flag. The bridge builds the memory address by taking the bitwise OR of the peripheral address with a base word supplied from a channel register. It then sends one or more memory commands and moves the data as halfword beats in both directions, with a valid/ready handshake on every stream.

In swap mode the bridge clears bit 0 of both the address and the length. It also exchanges the two bytes of every halfword, whichever way the data flows. A swap-mode write to memory is cut into commands that carry at most 64 bytes each. Each command starts where the previous one ended. Without swap mode the address (after the OR) and the length are used as given, the data is not changed, and the whole transfer goes out as a single command.

A transfer whose length is zero after rounding sends nothing to memory. A one-cycle completion pulse marks the end of every transfer.

Top module: `hsb_bridge`

## Requirements
- R1: The first memory command address equals the request address OR the base word, both taken at request acceptance. Without swap mode no other bit is changed.
- R2: In swap mode, bit 0 of every memory command address and of every command length is zero. The length is the request length with bit 0 cleared.
- R3: In swap mode every beat has its bytes exchanged: bits [15:8] go to [7:0] and bits [7:0] go to [15:8]. This holds from the peripheral to memory (writes) and from memory to the peripheral (reads). Without swap mode, beats pass unchanged.
- R4: A swap-mode write issues commands of min(remaining, 64) bytes. Each later command address equals the previous address plus the previous length, and the lengths add up to the rounded request length.
- R5: A non-swap transfer, and a swap-mode read, issues exactly one memory command carrying the full length. The write flag of each command (1 = to memory) equals the request direction.
- R6: A request whose length is zero after rounding issues no memory command and no data beat. `done` is high in the cycle after acceptance.
- R7: `done` is high for exactly one cycle. It follows the cycle in which the last beat of the last command was handed over: taken by memory for a write, or taken by the peripheral for a read. It is low at all other times.
- R8: The swap flag, the direction and the base word are sampled when the request is accepted. Changing them during the transfer has no effect on data or addresses.
- R9: `reqReady` is high only while no transfer is in progress, and it is high after reset.
- R10: A memory command that is offered but not yet accepted keeps its valid, address and length unchanged. Each command is followed by ceil(length/2) data beats before the next command is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Peripheral request offered |
| reqReady | output | 1 | Bridge idle, takes the request |
| reqAddr | input | 32 | Peripheral byte address |
| reqLen | input | 16 | Transfer length in bytes |
| reqWrite | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| reqSwap | input | 1 | 1 = halfword byte-swap mode |
| baseAddr | input | 32 | Base word OR-ed into the address |
| wrDataValid | input | 1 | Peripheral write beat valid |
| wrDataReady | output | 1 | Peripheral write beat taken |
| wrData | input | 16 | Peripheral write beat |
| rdDataValid | output | 1 | Read beat to peripheral valid |
| rdDataReady | input | 1 | Peripheral takes read beat |
| rdData | output | 16 | Read beat to peripheral |
| memCmdValid | output | 1 | Memory command offered |
| memCmdReady | input | 1 | Memory takes command |
| memCmdAddr | output | 32 | Command byte address |
| memCmdLen | output | 16 | Command length in bytes |
| memCmdWrite | output | 1 | Command direction, 1 = write to memory |
| memWrValid | output | 1 | Write beat to memory valid |
| memWrReady | input | 1 | Memory takes write beat |
| memWrData | output | 16 | Write beat to memory |
| memRdValid | input | 1 | Memory read beat valid |
| memRdReady | output | 1 | Bridge takes read beat |
| memRdData | input | 16 | Memory read beat |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The checker learns the swap flag and direction only from the request handshake. It therefore assumes that the request fields are stable while `reqValid` is high and not yet taken. It also assumes that memory delivers read beats only as answers to the command just issued. The bench meets both conditions: it holds every request field from the moment it raises `reqValid` until the handshake, and it changes those fields only after acceptance. Its memory model gates every ready and valid signal with fixed cycle patterns, so commands and beats stall in many phase combinations. Data values come from running counters, so every beat is unique and any mixing of swap and pass-through shows up.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic acceptReq;   // load a new request
    logic issueChunk;  // command handshake this cycle
    logic cmdPhase;    // command being offered
    logic xferPhase;   // data beats of current chunk
  } hsb_strobe_t;

  // Datapath-to-control status
  typedef struct packed {
    logic reqLenZero;  // incoming request has zero rounded length
    logic remZero;     // nothing left after the current chunk
    logic lastBeat;    // one beat left in the current chunk
    logic beatFire;    // a data beat moves this cycle
  } hsb_status_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_XFER = 2'd2
  } hsb_state_t;

endpackage

// File: rtl/hsb_swap.sv
module hsb_swap #(
  parameter int DATA_W = 16
) (
  input  logic              swapEn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  localparam int HALVES = DATA_W / 16;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_comb begin
      if (swapEn) begin
        dOut[16*h +: 8]     = dIn[16*h + 8 +: 8];
        dOut[16*h + 8 +: 8] = dIn[16*h +: 8];
      end else begin
        dOut[16*h +: 16] = dIn[16*h +: 16];
      end
    end
  end
endmodule

// File: rtl/hsb_datapath.sv
module hsb_datapath
  import hsb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsb_strobe_t       strobe,
  output hsb_status_t       status,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              reqSwap,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              wrDataValid,
  output logic              wrDataReady,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdDataValid,
  input  logic              rdDataReady,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [LEN_W-1:0]  memCmdLen,
  output logic              memCmdWrite,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memRdValid,
  output logic              memRdReady,
  input  logic [DATA_W-1:0] memRdData
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SH    = $clog2(BEAT_BYTES);
  localparam logic [LEN_W-1:0] CHUNK_L   = LEN_W'(CHUNK_BYTES);
  localparam logic [LEN_W-1:0] BEAT_MASK = LEN_W'(BEAT_BYTES - 1);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [LEN_W-1:0]  beatsLeft;
  logic              swapQ;
  logic              writeQ;

  logic [ADDR_W-1:0] effAddr;
  logic [LEN_W-1:0]  effLen;
  logic [LEN_W-1:0]  chunkLen;
  logic [LEN_W-1:0]  chunkBeats;
  logic              beatFire;

  // request rounding and base combination
  always_comb begin
    effAddr = reqAddr | baseAddr;
    effLen  = reqLen;
    if (reqSwap) begin
      effAddr[0] = 1'b0;
      effLen[0]  = 1'b0;
    end
  end

  // chunk size: bounded only for swapped writes
  always_comb begin
    chunkLen = remLen;
    if (swapQ && writeQ && (remLen > CHUNK_L)) chunkLen = CHUNK_L;
    chunkBeats = (chunkLen >> BEAT_SH) +
                 LEN_W'(((chunkLen & BEAT_MASK) != '0) ? 1 : 0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remLen    <= '0;
      beatsLeft <= '0;
      swapQ     <= 1'b0;
      writeQ    <= 1'b0;
    end else begin
      if (strobe.acceptReq) begin
        curAddr <= effAddr;
        remLen  <= effLen;
        swapQ   <= reqSwap;
        writeQ  <= reqWrite;
      end
      if (strobe.issueChunk) begin
        curAddr   <= curAddr + ADDR_W'(chunkLen);
        remLen    <= remLen - chunkLen;
        beatsLeft <= chunkBeats;
      end else if (beatFire) begin
        beatsLeft <= beatsLeft - 1'b1;
      end
    end
  end

  // stream gating
  assign memWrValid  = strobe.xferPhase &&  writeQ && wrDataValid;
  assign wrDataReady = strobe.xferPhase &&  writeQ && memWrReady;
  assign rdDataValid = strobe.xferPhase && !writeQ && memRdValid;
  assign memRdReady  = strobe.xferPhase && !writeQ && rdDataReady;

  assign beatFire = writeQ ? (memWrValid && memWrReady)
                           : (rdDataValid && rdDataReady);

  hsb_swap #(.DATA_W(DATA_W)) u_wrSwap (
    .swapEn (swapQ),
    .dIn    (wrData),
    .dOut   (memWrData)
  );

  hsb_swap #(.DATA_W(DATA_W)) u_rdSwap (
    .swapEn (swapQ),
    .dIn    (memRdData),
    .dOut   (rdData)
  );

  assign memCmdAddr  = curAddr;
  assign memCmdLen   = chunkLen;
  assign memCmdWrite = writeQ;

  always_comb begin
    status.reqLenZero = (effLen == '0);
    status.remZero    = (remLen == '0);
    status.lastBeat   = (beatsLeft == LEN_W'(1));
    status.beatFire   = beatFire;
  end
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
  import hsb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memCmdReady,
  input  hsb_status_t status,
  output hsb_strobe_t strobe,
  output logic        reqReady,
  output logic        memCmdValid,
  output logic        done
);
  hsb_state_t state;
  hsb_state_t stateNext;
  logic       doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        strobe.acceptReq = reqValid;
        if (reqValid) begin
          if (status.reqLenZero) doneNext  = 1'b1;
          else                   stateNext = ST_CMD;
        end
      end
      ST_CMD: begin
        strobe.cmdPhase   = 1'b1;
        strobe.issueChunk = memCmdReady;
        if (memCmdReady) stateNext = ST_XFER;
      end
      ST_XFER: begin
        strobe.xferPhase = 1'b1;
        if (status.beatFire && status.lastBeat) begin
          if (status.remZero) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            stateNext = ST_CMD;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memCmdValid = (state == ST_CMD);
endmodule

// File: rtl/hsb_bridge.sv
module hsb_bridge
  import hsb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              reqSwap,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              wrDataValid,
  output logic              wrDataReady,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdDataValid,
  input  logic              rdDataReady,
  output logic [DATA_W-1:0] rdData,
  output logic              memCmdValid,
  input  logic              memCmdReady,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [LEN_W-1:0]  memCmdLen,
  output logic              memCmdWrite,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memRdValid,
  output logic              memRdReady,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done
);
  hsb_strobe_t strobe;
  hsb_status_t status;

  hsb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memCmdReady (memCmdReady),
    .status      (status),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memCmdValid (memCmdValid),
    .done        (done)
  );

  hsb_datapath #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .DATA_W      (DATA_W),
    .CHUNK_BYTES (CHUNK_BYTES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .status      (status),
    .reqAddr     (reqAddr),
    .reqLen      (reqLen),
    .reqWrite    (reqWrite),
    .reqSwap     (reqSwap),
    .baseAddr    (baseAddr),
    .wrDataValid (wrDataValid),
    .wrDataReady (wrDataReady),
    .wrData      (wrData),
    .rdDataValid (rdDataValid),
    .rdDataReady (rdDataReady),
    .rdData      (rdData),
    .memCmdAddr  (memCmdAddr),
    .memCmdLen   (memCmdLen),
    .memCmdWrite (memCmdWrite),
    .memWrValid  (memWrValid),
    .memWrReady  (memWrReady),
    .memWrData   (memWrData),
    .memRdValid  (memRdValid),
    .memRdReady  (memRdReady),
    .memRdData   (memRdData)
  );
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 16,
  parameter int CHUNK_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              reqSwap,
  input logic              memCmdValid,
  input logic              memCmdReady,
  input logic [ADDR_W-1:0] memCmdAddr,
  input logic [LEN_W-1:0]  memCmdLen,
  input logic              rdDataValid,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] memRdData
);
  logic swapC;
  logic writeC;
  logic issuedC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swapC   <= 1'b0;
      writeC  <= 1'b0;
      issuedC <= 1'b0;
    end else if (reqValid && reqReady) begin
      swapC   <= reqSwap;
      writeC  <= reqWrite;
      issuedC <= 1'b0;
    end else if (memCmdValid && memCmdReady) begin
      issuedC <= 1'b1;
    end
  end

  assert_even_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && swapC |-> !memCmdAddr[0] && !memCmdLen[0]);

  assert_chunk_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && swapC && writeC |-> memCmdLen <= LEN_W'(CHUNK_BYTES));

  assert_single_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && !(swapC && writeC) |-> !issuedC);

  assert_nonzero_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |-> memCmdLen != '0);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |-> !reqReady);

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && !memCmdReady |=> memCmdValid && $stable(memCmdAddr) && $stable(memCmdLen));

  assert_rd_swap_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdDataValid && swapC |-> rdData[7:0] == memRdData[15:8] && rdData[15:8] == memRdData[7:0]);
endmodule

bind hsb_bridge hsb_checker #(
  .ADDR_W      (ADDR_W),
  .LEN_W       (LEN_W),
  .DATA_W      (DATA_W),
  .CHUNK_BYTES (CHUNK_BYTES)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqWrite    (reqWrite),
  .reqSwap     (reqSwap),
  .memCmdValid (memCmdValid),
  .memCmdReady (memCmdReady),
  .memCmdAddr  (memCmdAddr),
  .memCmdLen   (memCmdLen),
  .rdDataValid (rdDataValid),
  .rdData      (rdData),
  .memRdData   (memRdData)
);

// File: tb/hsb_bridge_bench.sv
`timescale 1ns/100ps
module hsb_bridge_bench;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 16;
  localparam int CH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqReady;
  logic [AW-1:0] reqAddr = '0, baseAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic          reqWrite = 1'b0, reqSwap = 1'b0;
  logic          wrDataValid = 1'b0, wrDataReady;
  logic [DW-1:0] wrData = '0;
  logic          rdDataValid, rdDataReady = 1'b0;
  logic [DW-1:0] rdData;
  logic          memCmdValid, memCmdReady = 1'b0;
  logic [AW-1:0] memCmdAddr;
  logic [LW-1:0] memCmdLen;
  logic          memCmdWrite;
  logic          memWrValid, memWrReady = 1'b0;
  logic [DW-1:0] memWrData;
  logic          memRdValid = 1'b0, memRdReady;
  logic [DW-1:0] memRdData = '0;
  logic          done;

  hsb_bridge u_hsb_bridge (.*);

  typedef struct { logic [AW-1:0] a; logic [LW-1:0] l; logic w; } cmd_t;
  cmd_t        cmdQ[$];
  logic [15:0] beatQ[$];
  bit          lastQ[$];

  int  checks = 0, fails = 0;
  int  cyc = 0, wrIdx = 0, rdIdx = 0, doneCount = 0;
  bit  pendingDone = 0, finished = 0;

  function automatic logic [15:0] sw16(logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // memory and peripheral stream model
  initial begin
    forever begin
      bit rdFire, wrFire;
      @(negedge clk);
      rdFire = memRdValid && memRdReady;
      wrFire = wrDataValid && wrDataReady;
      @(posedge clk);
      #1;
      if (rdFire) rdIdx++;
      if (wrFire) wrIdx++;
      cyc++;
      memCmdReady = (cyc % 3) != 0;
      memWrReady  = (cyc % 4) != 1;
      memRdValid  = (cyc % 3) != 1;
      rdDataReady = (cyc % 5) != 2;
      wrDataValid = (cyc % 7) != 3;
      wrData      = 16'h1200 + 16'(wrIdx);
      memRdData   = 16'hA500 + 16'(rdIdx);
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      bit expDone;
      @(negedge clk);
      if (rstN) begin
        expDone = pendingDone;
        pendingDone = 0;
        if (reqValid && reqReady) begin
          logic [LW-1:0] eff;
          eff = reqSwap ? (reqLen & ~LW'(1)) : reqLen;
          if (eff == '0) pendingDone = 1;  // R6
        end
        if (memCmdValid && memCmdReady) begin
          check(!reqReady, "R9", "reqReady while busy", reqReady, 0);
          if (cmdQ.size() == 0) check(0, "R6", "unexpected command", memCmdAddr, 0);
          else begin
            cmd_t e;
            e = cmdQ.pop_front();
            check(memCmdAddr == e.a, "R1 R2 R4", "cmd addr", memCmdAddr, e.a);
            check(memCmdLen == e.l, "R2 R4 R5", "cmd len", memCmdLen, e.l);
            check(memCmdWrite == e.w, "R5", "cmd dir", memCmdWrite, e.w);
          end
        end
        if ((memWrValid && memWrReady) || (rdDataValid && rdDataReady)) begin
          logic [15:0] act;
          act = memWrValid ? memWrData : rdData;
          if (beatQ.size() == 0) check(0, "R10", "unexpected beat", act, 0);
          else begin
            logic [15:0] e;
            e = beatQ.pop_front();
            check(act == e, "R3 R8", "beat data", act, e);
            if (lastQ.pop_front()) pendingDone = 1;
          end
        end
        if (done || expDone)
          check(done == expDone, "R7", "done pulse", done, expDone);
        if (done) doneCount++;
      end
    end
  end

  task automatic run(logic [AW-1:0] addr, logic [LW-1:0] len, bit wr, bit sw,
                     logic [AW-1:0] base);
    logic [AW-1:0] cur;
    int rem, n, d0;
    cur = (addr | base) & ~AW'(sw);
    rem = int'(sw ? (len & ~LW'(1)) : len);
    n   = (rem + 1) / 2;
    if (sw && wr) begin
      while (rem > 0) begin
        int c;
        c = (rem > CH) ? CH : rem;
        cmdQ.push_back('{cur, LW'(c), wr});
        cur += AW'(c);
        rem -= c;
      end
    end else if (rem > 0) begin
      cmdQ.push_back('{cur, LW'(rem), wr});
    end
    for (int k = 0; k < n; k++) begin
      logic [15:0] v;
      v = wr ? 16'h1200 + 16'(wrIdx + k) : 16'hA500 + 16'(rdIdx + k);
      beatQ.push_back(sw ? sw16(v) : v);
      lastQ.push_back(k == n - 1);
    end
    d0 = doneCount;
    @(posedge clk); #1;
    reqAddr = addr; reqLen = len; reqWrite = wr; reqSwap = sw; baseAddr = base;
    reqValid = 1'b1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
    // R8: disturb sampled fields during the transfer
    reqSwap = ~sw; reqWrite = ~wr; baseAddr = ~base; reqAddr = '1;
    while (doneCount == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "reset reqReady", reqReady, 1);
    check(memCmdValid == 1'b0, "R10", "reset cmd valid", memCmdValid, 0);
    check(done == 1'b0, "R7", "reset done", done, 0);
    run(32'h0000_1003, 16'd7,   1, 0, 32'h4000_0010);  // R1 plain write, odd length
    run(32'h0000_0201, 16'd150, 1, 1, 32'h8000_0000);  // R4 chunks 64,64,22
    run(32'h0000_0011, 16'd9,   0, 1, 32'h0000_0100);  // R2 R3 swapped read
    run(32'h0000_0022, 16'd5,   0, 0, 32'h0001_0000);  // R5 plain read
    run(32'h0000_0040, 16'd1,   1, 1, 32'h0);          // R6 rounds to zero
    run(32'h0000_0050, 16'd0,   0, 0, 32'h0);          // R6 zero length
    run(32'h0000_1000, 16'd128, 1, 1, 32'h0200_0000);  // R4 exact chunks
    run(32'h0000_3000, 16'd66,  1, 1, 32'h0000_0004);  // R4 64 then 2
    run(32'h0000_0005, 16'd200, 0, 1, 32'h0);          // R5 swapped read stays single
    check(cmdQ.size() == 0, "R4", "commands left", cmdQ.size(), 0);
    check(beatQ.size() == 0, "R10", "beats left", beatQ.size(), 0);
    finish_run();
  end
endmodule